// File: doc/BRIEF.md
# BCH Correction Engine Register Front-End

This block sits between a 32-bit register bus and a BCH error-correction engine. Software sets up a job in three steps. It programs the block length and the parity length, writes the control word with the initialise bit set, and pushes the payload through a data port. A data-port write carries either four bytes or a single byte. The block unpacks each write into a lane vector and counts every accepted byte against the configured lengths. When the job finishes, it latches the engine's completion and error results into a status register. Software clears that register by writing ones to it. An interrupt line reports the status flags that software has enabled.

The correction arithmetic itself is outside this block. A small behavioural engine stands in for it so that the register behaviour can be tested end to end. In encode mode it folds the data into the parity buffer: data byte j is XORed into parity byte j mod P. In decode mode it refolds the data and compares each received parity byte with the folded value. Every parity byte that differs becomes an error report, and the differing bits form that report's mask. Parity words and error reports are read back through two register banks.

Top module: `ecc_regfront`

## Requirements
- R1: After reset the control, count, status and interrupt-enable registers read 0 and `irq` is low.
- R2: The control register at 0x000 holds enable (bit 0), initialise (bit 1), encode (bit 2, 1 = encode, 0 = decode) and strength (bits 10:4). It reads back as written, with bit 3 reading 0. The initialise bit reads 0 again one cycle after the write that set it.
- R3: Writing to 0x008 clears every control bit for which the written word has a 1. The other control bits keep their values.
- R4: The count register at 0x00C holds the block length in bytes (bits 10:0) and the parity length in bytes (bits 22:16). All other bits read 0.
- R5: A write to 0x010 with `bus_byte` low delivers four bytes, wdata[7:0] first. With `bus_byte` high it delivers the single byte wdata[7:0]. Bytes are ignored while enable is 0, and also once the job's target byte count has been reached.
- R6: In encode mode, status bit 2 is set once the block-length number of data bytes has been accepted. Parity byte k is the XOR of every data byte j with j mod P = k, where P is the parity length. Parity word w reads at 0x014+4w and holds bytes 4w..4w+3 with the lowest index in bits 7:0. Bytes at index P and above read 0.
- R7: In decode mode, the block-length data bytes are followed by P parity bytes, and status bit 3 is set after the last of them. Each received parity byte k that differs from folded byte k produces one report at 0x084+4i, filled in ascending k: bits 10:0 hold k and bits 23:16 hold the XOR difference. Status bit 0 is set if any report exists. Bits 22:16 hold the total number of differing bits and bits 30:24 hold the number of reports.
- R8: Status bit 1 (uncorrectable) is set when the number of differing parity bytes exceeds the strength field.
- R9: A write to the status register at 0x184 clears each flag in bits 3:0 for which the written bit is 1. A 1 in bit 0 also clears both count fields. Writing back the value just read therefore leaves the register at 0.
- R10: Setting initialise clears the byte counter, the parity buffer, the error reports and the whole status register.
- R11: The interrupt-enable register reads at 0x190. Writing ones to 0x188 sets its bits and writing ones to 0x18C clears them. `irq` is the OR of status bits 3:0 ANDed with the enable bits, registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address of the register access, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_byte | input | 1 | Data-port write carries one byte instead of four |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Encode jobs are run with a block length that is a multiple of four and with block lengths that need trailing byte writes. Matching parity with both kinds shows that word and single-byte writes land in the right order. A parity length that is not a multiple of four shows that unused byte lanes read 0. Decode jobs are run with clean parity, with corruption below the strength limit and with corruption above it. These separate the no-error case from the error-report fields and from the uncorrectable flag. One decode stream has a word write that straddles the data/parity boundary, which shows that bytes are classified one by one. Directed cases cover disabled-engine writes, writes past the target count, write-one-to-clear, the interrupt mask and the initialise clear.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam logic [8:0] A_CTRL  = 9'h000;
  localparam logic [8:0] A_CCLR  = 9'h008;
  localparam logic [8:0] A_COUNT = 9'h00C;
  localparam logic [8:0] A_DATA  = 9'h010;
  localparam logic [8:0] A_PAR   = 9'h014;
  localparam logic [8:0] A_REP   = 9'h084;
  localparam logic [8:0] A_STAT  = 9'h184;
  localparam logic [8:0] A_IESET = 9'h188;
  localparam logic [8:0] A_IECLR = 9'h18C;
  localparam logic [8:0] A_IE    = 9'h190;
  localparam logic [10:0] CTRL_MASK = 11'h7F7;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/ecc_port_unpack.sv
module ecc_port_unpack #(
  parameter int LANES = 4
) (
  input  logic                 hit,
  input  logic                 byte_mode,
  input  logic [LANES*8-1:0]   wdata,
  output logic                 vld,
  output logic [LANES*8-1:0]   lanes,
  output logic [2:0]           count
);
  assign vld = hit;
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_first
        assign lanes[7:0] = wdata[7:0];
      end else begin : g_rest
        assign lanes[8*g +: 8] = byte_mode ? 8'h00 : wdata[8*g +: 8];
      end
    end
  endgenerate
  assign count = byte_mode ? 3'd1 : 3'(LANES);
endmodule

// File: rtl/ecc_stub_engine.sv
module ecc_stub_engine #(
  parameter int PAR_BYTES = 128,
  parameter int REP_DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   init,
  input  logic                   enable,
  input  logic                   encode,
  input  logic [10:0]            blk_len,
  input  logic [6:0]             par_len,
  input  logic [6:0]             strength,
  input  logic                   in_vld,
  input  logic [31:0]            in_lanes,
  input  logic [2:0]             in_count,
  output logic                   done,
  output logic                   err_found,
  output logic                   uncorrectable,
  output logic [6:0]             bit_total,
  output logic [6:0]             rep_count,
  output logic [PAR_BYTES*8-1:0] par_flat,
  output logic [REP_DEPTH*32-1:0] rep_flat
);
  localparam int PI = $clog2(PAR_BYTES);
  localparam int RI = $clog2(REP_DEPTH);

  logic [11:0] cnt_q, cnt_n;
  logic [6:0]  pos_q, pos_n;
  logic [7:0]  fold_q [PAR_BYTES];
  logic [7:0]  fold_n [PAR_BYTES];
  logic [6:0]  mis_q, mis_n, bits_q, bits_n;
  logic [31:0] rep_q [REP_DEPTH];
  logic [31:0] rep_n [REP_DEPTH];
  logic        fin_q, fin_n, done_q, done_n;
  logic [11:0] target;
  logic [7:0]  cur_b, diff, bsum;
  logic [6:0]  pidx;

  assign target = encode ? {1'b0, blk_len} : ({1'b0, blk_len} + {5'd0, par_len});

  // Up to four bytes per cycle, each classified as data or parity on its own.
  always_comb begin
    cnt_n = cnt_q; pos_n = pos_q; fold_n = fold_q; mis_n = mis_q;
    bits_n = bits_q; rep_n = rep_q; fin_n = fin_q; done_n = 1'b0;
    cur_b = '0; diff = '0; pidx = '0; bsum = '0;
    for (int i = 0; i < 4; i++) begin
      if (in_vld && enable && (i < int'(in_count)) && !fin_n && (cnt_n < target)) begin
        cur_b = in_lanes[8*i +: 8];
        if (cnt_n < {1'b0, blk_len}) begin
          if (par_len != 7'd0) begin
            fold_n[pos_n[PI-1:0]] = fold_n[pos_n[PI-1:0]] ^ cur_b;
            pos_n = (pos_n + 7'd1 == par_len) ? 7'd0 : pos_n + 7'd1;
          end
        end else begin
          pidx = 7'(cnt_n - {1'b0, blk_len});
          diff = fold_n[pidx[PI-1:0]] ^ cur_b;
          if (diff != 8'h00) begin
            if (int'(mis_n) < REP_DEPTH) rep_n[mis_n[RI-1:0]] = {8'h00, diff, 9'h000, pidx};
            mis_n = (mis_n == 7'h7F) ? mis_n : mis_n + 7'd1;
            bsum = {1'b0, bits_n} + 8'($countones(diff));
            bits_n = bsum[7] ? 7'h7F : bsum[6:0];
          end
        end
        cnt_n = cnt_n + 12'd1;
        if (cnt_n == target) begin
          fin_n = 1'b1;
          done_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      cnt_q <= '0; pos_q <= '0; mis_q <= '0; bits_q <= '0;
      fin_q <= 1'b0; done_q <= 1'b0;
      for (int i = 0; i < PAR_BYTES; i++) fold_q[i] <= '0;
      for (int i = 0; i < REP_DEPTH; i++) rep_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n; pos_q <= pos_n; mis_q <= mis_n; bits_q <= bits_n;
      fin_q <= fin_n; done_q <= done_n;
      fold_q <= fold_n;
      rep_q <= rep_n;
    end
  end

  generate
    for (genvar g = 0; g < PAR_BYTES; g++) begin : g_par
      assign par_flat[8*g +: 8] = fold_q[g];
    end
    for (genvar g = 0; g < REP_DEPTH; g++) begin : g_rep
      assign rep_flat[32*g +: 32] = rep_q[g];
    end
  endgenerate

  assign done          = done_q;
  assign err_found     = (mis_q != 7'd0);
  assign uncorrectable = (mis_q > strength);
  assign bit_total     = bits_q;
  assign rep_count     = (int'(mis_q) > REP_DEPTH) ? 7'(REP_DEPTH) : mis_q;

  // R6: completion is a single-cycle pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R10: initialise empties the counter and the error statistics
  assert_init_clears_R10: assert property (@(posedge clk) disable iff (rst)
    init |=> (cnt_q == 12'd0 && mis_q == 7'd0 && bits_q == 7'd0));
  // R5: nothing is counted once the job has finished
  assert_hold_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    (fin_q && !init) |=> $stable(cnt_q));
endmodule

// File: rtl/ecc_regfront.sv
module ecc_regfront
  import ecc_pkg::*;
#(
  parameter int PAR_BYTES  = 128,
  parameter int REP_DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [8:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_byte,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic [10:0] ctrl_q;
  logic [10:0] blk_q;
  logic [6:0]  npar_q;
  logic [FLAG_W-1:0] flags_q, ie_q;
  logic [6:0]  tot_q, nrep_q;
  logic        irq_q;
  logic [31:0] rdata_q, rd_next;

  logic wr_ctrl, wr_cclr, wr_cnt, wr_data, wr_stat, wr_ieset, wr_ieclr;
  assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  assign wr_cclr  = bus_wr && bus_addr == A_CCLR;
  assign wr_cnt   = bus_wr && bus_addr == A_COUNT;
  assign wr_data  = bus_wr && bus_addr == A_DATA;
  assign wr_stat  = bus_wr && bus_addr == A_STAT;
  assign wr_ieset = bus_wr && bus_addr == A_IESET;
  assign wr_ieclr = bus_wr && bus_addr == A_IECLR;

  logic        in_vld;
  logic [31:0] in_lanes;
  logic [2:0]  in_count;
  logic        eng_done, eng_err, eng_uncor;
  logic [6:0]  eng_bits, eng_reps;
  logic [PAR_BYTES*8-1:0]  par_flat;
  logic [REP_DEPTH*32-1:0] rep_flat;

  ecc_port_unpack #(.LANES(4)) u_unpack (
    .hit(wr_data), .byte_mode(bus_byte), .wdata(bus_wdata),
    .vld(in_vld), .lanes(in_lanes), .count(in_count)
  );

  ecc_stub_engine #(.PAR_BYTES(PAR_BYTES), .REP_DEPTH(REP_DEPTH)) u_engine (
    .clk(clk), .rst(rst), .init(ctrl_q[1]), .enable(ctrl_q[0]), .encode(ctrl_q[2]),
    .blk_len(blk_q), .par_len(npar_q), .strength(ctrl_q[10:4]),
    .in_vld(in_vld), .in_lanes(in_lanes), .in_count(in_count),
    .done(eng_done), .err_found(eng_err), .uncorrectable(eng_uncor),
    .bit_total(eng_bits), .rep_count(eng_reps),
    .par_flat(par_flat), .rep_flat(rep_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      blk_q <= '0;
      npar_q <= '0;
      ie_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[10:0] & CTRL_MASK;
      else if (wr_cclr) ctrl_q <= ctrl_q & ~bus_wdata[10:0] & ~11'h002;
      else ctrl_q[1] <= 1'b0;
      if (wr_cnt) begin
        blk_q <= bus_wdata[10:0];
        npar_q <= bus_wdata[22:16];
      end
      if (wr_ieset) ie_q <= ie_q | bus_wdata[FLAG_W-1:0];
      else if (wr_ieclr) ie_q <= ie_q & ~bus_wdata[FLAG_W-1:0];
    end
  end

  // Status: initialise clears, a completion sets, a write of ones clears.
  always_ff @(posedge clk) begin
    if (rst || ctrl_q[1]) begin
      flags_q <= '0;
      tot_q <= '0;
      nrep_q <= '0;
    end else if (eng_done) begin
      flags_q <= (wr_stat ? (flags_q & ~bus_wdata[3:0]) : flags_q)
               | {!ctrl_q[2], ctrl_q[2], eng_uncor, eng_err};
      tot_q <= eng_bits;
      nrep_q <= eng_reps;
    end else if (wr_stat) begin
      flags_q <= flags_q & ~bus_wdata[3:0];
      if (bus_wdata[0]) begin
        tot_q <= '0;
        nrep_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= |(flags_q & ie_q);
  end

  logic [8:0] par_off, rep_off;
  logic [4:0] pword;
  logic [5:0] rword;
  assign par_off = bus_addr - A_PAR;
  assign rep_off = bus_addr - A_REP;
  assign pword = par_off[6:2];
  assign rword = rep_off[7:2];

  always_comb begin
    rd_next = '0;
    if (bus_addr == A_CTRL || bus_addr == A_CCLR) rd_next = {21'd0, ctrl_q};
    else if (bus_addr == A_COUNT) rd_next = {9'd0, npar_q, 5'd0, blk_q};
    else if (bus_addr == A_STAT) rd_next = {1'b0, nrep_q, 1'b0, tot_q, 12'd0, flags_q};
    else if (bus_addr == A_IE) rd_next = {28'd0, ie_q};
    else if (bus_addr >= A_PAR && bus_addr < A_REP) begin
      for (int b = 0; b < 4; b++) begin
        if (int'(pword) * 4 + b < int'(npar_q) && int'(pword) * 4 + b < PAR_BYTES)
          rd_next[8*b +: 8] = par_flat[8*(int'(pword) * 4 + b) +: 8];
      end
    end else if (bus_addr >= A_REP && bus_addr < A_STAT) begin
      if (int'(rword) < REP_DEPTH) rd_next = rep_flat[32*int'(rword) +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign irq = irq_q;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:23], bus_wdata[15:11], par_off[8:7], par_off[1:0],
                          rep_off[8], rep_off[1:0]};

  // R2: initialise lasts one cycle unless rewritten
  assert_init_selfclear_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1] && !wr_ctrl) |=> !ctrl_q[1]);
  // R11: with no enabled flag for two cycles the line stays low
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (ie_q == '0 && $past(ie_q) == '0) |-> !irq_q);
  // R9: a write of one to the encode flag clears it absent a new completion
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && bus_wdata[2] && !eng_done && !ctrl_q[1]) |=> !flags_q[2]);
  // R3: the clear alias never sets a control bit
  assert_cclr_only_clears_R3: assert property (@(posedge clk) disable iff (rst)
    wr_cclr |=> ((ctrl_q & ~$past(ctrl_q)) == 11'd0));
endmodule

// File: tb/ecc_regfront_tb.sv
module ecc_regfront_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ecc_regfront u_dut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  typedef struct packed {
    logic       enc;
    logic [10:0] blk;
    logic [6:0] npar;
    logic [6:0] str;
    logic [6:0] nflip;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 11'd16, 7'd4, 7'd0, 7'd0, 8'd3},
    '{1'b1, 11'd13, 7'd7, 7'd0, 7'd0, 8'd5},
    '{1'b1, 11'd9,  7'd3, 7'd0, 7'd0, 8'd11},
    '{1'b0, 11'd12, 7'd4, 7'd4, 7'd0, 8'd7},
    '{1'b0, 11'd12, 7'd4, 7'd4, 7'd2, 8'd9},
    '{1'b0, 11'd10, 7'd5, 7'd1, 7'd3, 8'd13}
  };

  logic [7:0] strm [256];
  logic [7:0] fold [128];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic bmode);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_byte = bmode; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int len);
    int j = 0;
    while (len - j >= 4) begin
      wr(9'h010, {strm[j+3], strm[j+2], strm[j+1], strm[j]}, 1'b0);
      j += 4;
    end
    while (j < len) begin
      wr(9'h010, {24'h0, strm[j]}, 1'b1);
      j++;
    end
  endtask

  task automatic start(input logic [10:0] blk, input logic [6:0] npar,
                       input logic [6:0] str, input logic enc);
    wr(9'h00C, {9'h0, npar, 5'h0, blk}, 1'b0);
    wr(9'h000, {21'h0, str, 1'b0, enc, 2'b11}, 1'b0);
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=%08h exp=%08h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(9'h000, v); chk("R1 ctrl", v, 32'h0);
    rd(9'h00C, v); chk("R1 count", v, 32'h0);
    rd(9'h184, v); chk("R1 status", v, 32'h0);
    rd(9'h190, v); chk("R1 ie", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 readback, R3 clear alias, R4 count fields
    wr(9'h000, 32'h0000_07F5, 1'b0);
    rd(9'h000, v); chk("R2 ctrl readback", v, 32'h0000_07F5);
    wr(9'h008, 32'h0000_0004, 1'b0);
    rd(9'h000, v); chk("R3 ctrl clear", v, 32'h0000_07F1);
    wr(9'h00C, 32'hFFFF_FFFF, 1'b0);
    rd(9'h00C, v); chk("R4 count mask", v, 32'h007F_07FF);
    wr(9'h000, 32'h0000_0007, 1'b0);
    idle(2);
    rd(9'h000, v); chk("R2 init self-clear", v, 32'h0000_0005);

    // Vector walk: R6 encode, R7 decode, R8 uncorrectable
    for (int n = 0; n < 6; n++) begin
      vec_t t = VECS[n];
      int blk = int'(t.blk);
      int np = int'(t.npar);
      int nf = int'(t.nflip);
      for (int k = 0; k < 128; k++) fold[k] = 8'h00;
      for (int j = 0; j < blk; j++) begin
        strm[j] = 8'(j * int'(t.seed) + 'h35);
        fold[j % np] ^= strm[j];
      end
      for (int k = 0; k < np; k++) strm[blk + k] = (k < nf) ? (fold[k] ^ 8'h81) : fold[k];
      start(t.blk, t.npar, t.str, t.enc);
      send(t.enc ? blk : blk + np);
      idle(6);
      rd(9'h184, v);
      if (t.enc) begin
        chk("R6 encode status", v, 32'h0000_0004);
        for (int w = 0; w < (np + 3) / 4; w++) begin
          exp = '0;
          for (int b = 0; b < 4; b++) if (4 * w + b < np) exp[8*b +: 8] = fold[4 * w + b];
          rd(9'h014 + 9'(4 * w), v);
          chk("R6 parity word", v, exp);
        end
      end else begin
        exp = {1'b0, 7'(nf), 1'b0, 7'(2 * nf), 12'h0, 1'b1, 1'b0,
               (nf > int'(t.str)), (nf != 0)};
        chk("R7 R8 decode status", v, exp);
        for (int i = 0; i < nf; i++) begin
          rd(9'h084 + 9'(4 * i), v);
          chk("R7 report entry", v, 32'h0081_0000 | 32'(i));
        end
      end
    end

    // R9 write back the status just read
    rd(9'h184, v);
    wr(9'h184, v, 1'b0);
    rd(9'h184, v); chk("R9 w1c writeback", v, 32'h0);

    // R5 bytes ignored while disabled, then accepted after re-enable
    start(11'd4, 7'd2, 7'd0, 1'b1);
    wr(9'h008, 32'h0000_0001, 1'b0);
    wr(9'h010, 32'h0403_0201, 1'b0);
    idle(6);
    rd(9'h184, v); chk("R5 disabled ignored", v, 32'h0);
    wr(9'h000, 32'h0000_0005, 1'b0);
    wr(9'h010, 32'h0403_0201, 1'b0);
    idle(6);
    rd(9'h184, v); chk("R5 re-enabled done", v, 32'h0000_0004);
    rd(9'h014, v); chk("R5 parity after re-enable", v, 32'h0000_0602);

    // R5 bytes past the target are ignored
    start(11'd4, 7'd2, 7'd0, 1'b1);
    wr(9'h010, 32'h0403_0201, 1'b0);
    wr(9'h010, 32'hFFFF_FFFF, 1'b0);
    idle(6);
    rd(9'h014, v); chk("R5 extra bytes ignored", v, 32'h0000_0602);
    wr(9'h184, 32'h0000_0004, 1'b0);
    rd(9'h184, v); chk("R9 single flag clear", v, 32'h0);

    // R11 interrupt enable
    wr(9'h188, 32'h0000_0004, 1'b0);
    rd(9'h190, v); chk("R11 ie set", v, 32'h0000_0004);
    start(11'd4, 7'd2, 7'd0, 1'b1);
    wr(9'h010, 32'h0403_0201, 1'b0);
    idle(6);
    chk("R11 irq high", {31'h0, irq}, 32'h1);
    wr(9'h18C, 32'h0000_0004, 1'b0);
    idle(3);
    chk("R11 irq masked", {31'h0, irq}, 32'h0);
    rd(9'h190, v); chk("R11 ie clear", v, 32'h0);

    // R10 initialise clears status and parity
    wr(9'h000, 32'h0000_0007, 1'b0);
    idle(2);
    rd(9'h184, v); chk("R10 status cleared", v, 32'h0);
    rd(9'h014, v); chk("R10 parity cleared", v, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule